// File: doc/BRIEF.md
# Concurrent Dual-Target Serial Configuration Loader

This block programs two slave-serial configurable devices in one pass. A host supplies two independent byte streams over ready/valid channels, one per target. The loader raises one program strobe that both targets share, waits until both report that their configuration memory is cleared, and then runs one configuration clock common to both targets. Each target has its own serial data line, and both lines shift in the same clock periods.

The two bitstreams may differ in length. The line of the target that runs out first is held at logic 1 until the longer stream ends. After both streams end, the clock keeps running for a set number of extra periods. The loader then samples each target's completion line and reports pass or fail for each target on its own. If a target's ready-for-data line never rises after the strobe, the loader stops with an error.

Top module: `dual_cfg_loader`

## Requirements
- R1: After reset, `cfg_prog` and `cfg_clk` are 0, both data lines are 1, both `*_ready` outputs are 0, and `busy` plus all result flags are 0.
- R2: A `start` pulse while idle drives `cfg_prog` high for exactly PROG_CYCLES system cycles, once. The configuration clock stays low while `cfg_prog` is high.
- R3: After the strobe, no clock edge is issued until both `init_a` and `init_b` are high. If they are not both high within INIT_TIMEOUT cycles, `init_err` is set, `fail_x` is set for each target whose init line is still low, `busy` drops, and no clock edge is ever produced.
- R4: Every high phase and every low phase of `cfg_clk` lasts at least HALF system cycles, where HALF = ceil(CLK_HZ / (2*MAX_CCLK_HZ)). The configuration clock therefore never exceeds MAX_CCLK_HZ (10 MHz by default).
- R5: Each target receives the first BITS_x bits of its stream, one bit per rising edge of `cfg_clk`, with both lines shifting in the same clock periods. Bit 7 of each byte goes first. If BITS_x is not a multiple of 8, only the upper bits of the last byte are sent.
- R6: A data line changes only while `cfg_clk` is low; it changes on the system edge where the clock falls. A data line never changes while `cfg_clk` is high.
- R7: Once a target's stream is used up, its data line is 1 at every remaining rising edge.
- R8: After the last real bit of the longer stream, exactly EXTRA_CLKS more rising edges occur. At the following falling edge, `ok_x` is set to `done_x` and `fail_x` to its inverse, separately for each target, and `busy` drops.
- R9: When the next bit of either stream is missing because the host is late, `cfg_clk` is held high until the bit arrives. No bit is lost or repeated.
- R10: `a_ready` and `b_ready` are high only while a load is in progress, and each channel accepts exactly ceil(BITS_x/8) bytes per load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (accepted when not busy) |
| a_data | input | 8 | Stream byte for target A |
| a_valid | input | 1 | `a_data` is valid |
| a_ready | output | 1 | Loader accepts a byte for target A |
| b_data | input | 8 | Stream byte for target B |
| b_valid | input | 1 | `b_data` is valid |
| b_ready | output | 1 | Loader accepts a byte for target B |
| cfg_prog | output | 1 | Shared program strobe, active high |
| cfg_clk | output | 1 | Shared configuration clock |
| cfg_dout_a | output | 1 | Serial data to target A |
| cfg_dout_b | output | 1 | Serial data to target B |
| init_a | input | 1 | Target A ready for data |
| init_b | input | 1 | Target B ready for data |
| done_a | input | 1 | Target A configuration complete |
| done_b | input | 1 | Target B configuration complete |
| busy | output | 1 | Load in progress |
| ok_a | output | 1 | Target A finished with done high |
| fail_a | output | 1 | Target A failed (done low or init timeout) |
| ok_b | output | 1 | Target B finished with done high |
| fail_b | output | 1 | Target B failed (done low or init timeout) |
| init_err | output | 1 | Init wait timed out |

## Verification
Two functions can land on the same system edge: a falling clock edge that advances a data line, and a host byte handshake that refills the same target's one-byte holding register. A third case is a falling edge that has to be held back because the holding register is empty. The stall test provokes both by spacing target A's bytes much farther apart than eight clock periods, while target B's bytes keep streaming. The test is judged at the target side. Every bit captured at a rising edge is compared against the bit position computed from the byte pattern. The test also checks that the longest gap between rising edges grew past one nominal period. The check that data never changes while the clock is high confirms that the held edge did not disturb either line.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_WINIT, ST_SHIFT, ST_FLUSH, ST_TAIL, ST_DONE, ST_ERR
  } dcl_state_e;

  function automatic int ceil_div(int num, int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/dcl_cclk_gen.sv
module dcl_cclk_gen #(
  parameter int HALF = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic allow_fall,
  output logic cclk,
  output logic rise,
  output logic fall
);
  localparam int HW = $clog2(HALF + 1);

  logic [HW-1:0] hc;
  logic          expired;

  assign expired = run && (hc == HW'(HALF - 1));
  assign rise    = expired && !cclk;
  assign fall    = expired && cclk && allow_fall;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cclk <= 1'b0;
      hc   <= '0;
    end else if (rise || fall) begin
      cclk <= !cclk;
      hc   <= '0;
    end else if (!expired) begin
      hc <= hc + 1'b1;
    end
  end
endmodule

// File: rtl/dcl_bit_feeder.sv
module dcl_bit_feeder #(
  parameter int NBITS = 393632
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       arm,
  input  logic       fetch_en,
  input  logic       adv,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic       dout,
  output logic       avail,
  output logic       drained
);
  localparam int NBYTES = dcl_pkg::ceil_div(NBITS, 8);
  localparam int RW     = $clog2(NBITS + 1);
  localparam int BW     = $clog2(NBYTES + 1);

  logic [RW-1:0] rem;
  logic [BW-1:0] bytes_left;
  logic [7:0]    sh, hold;
  logic [3:0]    sh_cnt;
  logic          hold_full;
  logic          take, consume;

  assign drained  = (rem == '0);
  assign in_ready = fetch_en && !hold_full && (bytes_left != '0);
  assign take     = in_ready && in_valid;
  assign avail    = drained || (sh_cnt != 4'd0) || hold_full;
  assign consume  = adv && !drained && (sh_cnt == 4'd0) && hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem        <= '0;
      bytes_left <= '0;
      sh         <= '0;
      hold       <= '0;
      sh_cnt     <= '0;
      hold_full  <= 1'b0;
      dout       <= 1'b1;
    end else if (arm) begin
      rem        <= RW'(NBITS);
      bytes_left <= BW'(NBYTES);
      sh_cnt     <= '0;
      hold_full  <= 1'b0;
      dout       <= 1'b1;
    end else begin
      if (take) begin
        hold       <= in_data;
        bytes_left <= bytes_left - 1'b1;
      end
      hold_full <= take ? 1'b1 : (consume ? 1'b0 : hold_full);
      if (adv) begin
        if (drained) begin
          dout <= 1'b1;
        end else if (sh_cnt != 4'd0) begin
          dout   <= sh[7];
          sh     <= {sh[6:0], 1'b0};
          sh_cnt <= sh_cnt - 1'b1;
          rem    <= rem - 1'b1;
        end else if (hold_full) begin
          dout   <= hold[7];
          sh     <= {hold[6:0], 1'b0};
          sh_cnt <= 4'd7;
          rem    <= rem - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dual_cfg_loader.sv
module dual_cfg_loader #(
  parameter int CLK_HZ       = 100_000_000,
  parameter int MAX_CCLK_HZ  = 10_000_000,
  parameter int BITS_A       = 393632,
  parameter int BITS_B       = 393632,
  parameter int PROG_CYCLES  = 64,
  parameter int INIT_TIMEOUT = 100000,
  parameter int EXTRA_CLKS   = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] a_data,
  input  logic       a_valid,
  output logic       a_ready,
  input  logic [7:0] b_data,
  input  logic       b_valid,
  output logic       b_ready,
  output logic       cfg_prog,
  output logic       cfg_clk,
  output logic       cfg_dout_a,
  output logic       cfg_dout_b,
  input  logic       init_a,
  input  logic       init_b,
  input  logic       done_a,
  input  logic       done_b,
  output logic       busy,
  output logic       ok_a,
  output logic       fail_a,
  output logic       ok_b,
  output logic       fail_b,
  output logic       init_err
);
  import dcl_pkg::*;

  localparam int HALF = ceil_div(CLK_HZ, 2 * MAX_CCLK_HZ);
  localparam int CM1  = (PROG_CYCLES > INIT_TIMEOUT) ? PROG_CYCLES : INIT_TIMEOUT;
  localparam int CMAX = (CM1 > EXTRA_CLKS) ? CM1 : EXTRA_CLKS;
  localparam int TW   = $clog2(CMAX + 1);

  dcl_state_e    state;
  logic [TW-1:0] cnt;
  logic          primed, arm, fetch_en, prime, adv, run, allow_fall;
  logic          rise, fall, both_avail, all_drained;
  logic [1:0]    t_valid, t_ready, t_dout, t_avail, t_drained;
  logic [7:0]    t_data [2];

  assign t_data[0] = a_data;
  assign t_data[1] = b_data;
  assign t_valid   = {b_valid, a_valid};
  assign a_ready   = t_ready[0];
  assign b_ready   = t_ready[1];
  assign cfg_dout_a = t_dout[0];
  assign cfg_dout_b = t_dout[1];

  assign arm         = start && (state == ST_IDLE || state == ST_DONE || state == ST_ERR);
  assign fetch_en    = (state == ST_PROG) || (state == ST_WINIT) || (state == ST_SHIFT);
  assign both_avail  = &t_avail;
  assign all_drained = &t_drained;
  assign prime       = (state == ST_SHIFT) && !primed && both_avail;
  assign adv         = prime || fall;
  assign run         = ((state == ST_SHIFT) && primed) || (state == ST_FLUSH) || (state == ST_TAIL);
  assign allow_fall  = (state == ST_SHIFT) ? both_avail : 1'b1;

  dcl_cclk_gen #(.HALF(HALF)) u_cclk (
    .clk(clk), .rst(rst), .run(run), .allow_fall(allow_fall),
    .cclk(cfg_clk), .rise(rise), .fall(fall)
  );

  for (genvar g = 0; g < 2; g++) begin : g_tgt
    dcl_bit_feeder #(.NBITS(g == 0 ? BITS_A : BITS_B)) u_feed (
      .clk(clk), .rst(rst), .arm(arm), .fetch_en(fetch_en), .adv(adv),
      .in_data(t_data[g]), .in_valid(t_valid[g]), .in_ready(t_ready[g]),
      .dout(t_dout[g]), .avail(t_avail[g]), .drained(t_drained[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      primed   <= 1'b0;
      cfg_prog <= 1'b0;
      busy     <= 1'b0;
      ok_a     <= 1'b0;
      fail_a   <= 1'b0;
      ok_b     <= 1'b0;
      fail_b   <= 1'b0;
      init_err <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE, ST_ERR: begin
          if (start) begin
            state    <= ST_PROG;
            cnt      <= '0;
            primed   <= 1'b0;
            cfg_prog <= 1'b1;
            busy     <= 1'b1;
            ok_a     <= 1'b0;
            fail_a   <= 1'b0;
            ok_b     <= 1'b0;
            fail_b   <= 1'b0;
            init_err <= 1'b0;
          end
        end
        ST_PROG: begin
          if (cnt == TW'(PROG_CYCLES - 1)) begin
            cfg_prog <= 1'b0;
            state    <= ST_WINIT;
            cnt      <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WINIT: begin
          if (init_a && init_b) begin
            state <= ST_SHIFT;
            cnt   <= '0;
          end else if (cnt == TW'(INIT_TIMEOUT - 1)) begin
            state    <= ST_ERR;
            init_err <= 1'b1;
            fail_a   <= !init_a;
            fail_b   <= !init_b;
            busy     <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (prime) primed <= 1'b1;
          if (rise && all_drained) begin
            state <= ST_FLUSH;
            cnt   <= '0;
          end
        end
        ST_FLUSH: begin
          if (rise) begin
            if (cnt == TW'(EXTRA_CLKS - 1)) state <= ST_TAIL;
            else                            cnt   <= cnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (fall) begin
            state  <= ST_DONE;
            busy   <= 1'b0;
            ok_a   <= done_a;
            fail_a <= !done_a;
            ok_b   <= done_b;
            fail_b <= !done_b;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcl_checker.sv
module dcl_checker #(
  parameter int HALF = 5
) (
  input logic clk,
  input logic rst,
  input logic cfg_prog,
  input logic cfg_clk,
  input logic cfg_dout_a,
  input logic cfg_dout_b,
  input logic busy,
  input logic ok_a,
  input logic fail_a,
  input logic ok_b,
  input logic fail_b,
  input logic init_err,
  input logic a_ready,
  input logic b_ready
);
  logic        prev_clk;
  logic [15:0] since;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_clk <= 1'b0;
      since    <= '0;
    end else begin
      prev_clk <= cfg_clk;
      if (cfg_clk != prev_clk)  since <= '0;
      else if (since != 16'hFFFF) since <= since + 1'b1;
    end
  end

  assert_prog_clk_low_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_prog |-> !cfg_clk);

  assert_phase_min_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_clk != prev_clk) |-> (since >= 16'(HALF - 1)));

  assert_a_stable_high_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_clk |-> $stable(cfg_dout_a));

  assert_b_stable_high_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_clk |-> $stable(cfg_dout_b));

  assert_result_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(ok_a && fail_a) && !(ok_b && fail_b));

  assert_ready_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (a_ready || b_ready) |-> busy);

  assert_init_err_fail_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(init_err) |-> (fail_a || fail_b) && !busy);
endmodule

bind dual_cfg_loader dcl_checker #(.HALF(HALF)) u_chk (
  .clk(clk), .rst(rst), .cfg_prog(cfg_prog), .cfg_clk(cfg_clk),
  .cfg_dout_a(cfg_dout_a), .cfg_dout_b(cfg_dout_b), .busy(busy),
  .ok_a(ok_a), .fail_a(fail_a), .ok_b(ok_b), .fail_b(fail_b),
  .init_err(init_err), .a_ready(a_ready), .b_ready(b_ready)
);

// File: tb/dual_cfg_loader_tb.sv
`timescale 1ns/100ps
module dual_cfg_loader_tb;
  localparam int BA = 37, BB = 20, NBA = 5, NBB = 3;
  localparam int HALF = 10, EXTRA = 6, PROGC = 8;
  localparam int TOTAL = BA + EXTRA;

  logic clk = 0, rst = 1, start = 0;
  logic [7:0] a_data = 0, b_data = 0;
  logic a_valid = 0, b_valid = 0, a_ready, b_ready;
  logic cfg_prog, cfg_clk, cfg_dout_a, cfg_dout_b;
  logic init_a = 0, init_b = 0, done_a = 0, done_b = 0;
  logic busy, ok_a, fail_a, ok_b, fail_b, init_err;

  always #2.5 clk = ~clk;

  dual_cfg_loader #(.CLK_HZ(200_000_000), .MAX_CCLK_HZ(10_000_000),
    .BITS_A(BA), .BITS_B(BB), .PROG_CYCLES(PROGC), .INIT_TIMEOUT(200),
    .EXTRA_CLKS(EXTRA)) u_dut (
    .clk(clk), .rst(rst), .start(start),
    .a_data(a_data), .a_valid(a_valid), .a_ready(a_ready),
    .b_data(b_data), .b_valid(b_valid), .b_ready(b_ready),
    .cfg_prog(cfg_prog), .cfg_clk(cfg_clk), .cfg_dout_a(cfg_dout_a), .cfg_dout_b(cfg_dout_b),
    .init_a(init_a), .init_b(init_b), .done_a(done_a), .done_b(done_b),
    .busy(busy), .ok_a(ok_a), .fail_a(fail_a), .ok_b(ok_b), .fail_b(fail_b),
    .init_err(init_err));

  int tests = 0, fails = 0;
  bit finished = 0;
  int nr, since, min_int, max_int, prog_w, hs_a, hs_b, hi_chg;
  bit en_done_a, en_done_b, stop_feed;
  logic prev_clk = 0, prev_da = 1, prev_db = 1;
  logic cap_a [128];
  logic cap_b [128];

  function automatic logic [7:0] pat(int t, int k);
    return 8'hB4 ^ 8'(k * 29) ^ (t == 1 ? 8'h5A : 8'h00);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Target-side monitor: captures data at each rising configuration clock edge
  always @(negedge clk) begin
    if (cfg_clk && !prev_clk) begin
      if (nr < 128) begin
        cap_a[nr] = cfg_dout_a;
        cap_b[nr] = cfg_dout_b;
      end
      if (nr > 0) begin
        if (since + 1 < min_int) min_int = since + 1;
        if (since + 1 > max_int) max_int = since + 1;
      end
      nr++;
      since = 0;
    end else since++;
    if (cfg_clk && prev_clk && (cfg_dout_a != prev_da || cfg_dout_b != prev_db)) hi_chg++;
    if (cfg_prog) prog_w++;
    if (a_valid && a_ready) hs_a++;
    if (b_valid && b_ready) hs_b++;
    if (en_done_a && nr >= BA) done_a = 1;
    if (en_done_b && nr >= BB) done_b = 1;
    prev_clk = cfg_clk;
    prev_da = cfg_dout_a;
    prev_db = cfg_dout_b;
  end

  task automatic feed_a(int gap);
    for (int k = 0; k < NBA && !stop_feed; k++) begin
      repeat (gap) @(negedge clk);
      a_data = pat(0, k);
      a_valid = 1;
      while (!a_ready && !stop_feed) @(negedge clk);
      @(negedge clk);
      a_valid = 0;
    end
    a_data = 8'h00;
    a_valid = 1;  // surplus byte offered; must never be taken
  endtask

  task automatic feed_b(int gap);
    for (int k = 0; k < NBB && !stop_feed; k++) begin
      repeat (gap) @(negedge clk);
      b_data = pat(1, k);
      b_valid = 1;
      while (!b_ready && !stop_feed) @(negedge clk);
      @(negedge clk);
      b_valid = 0;
    end
    b_data = 8'h00;
    b_valid = 1;
  endtask

  task automatic run_load(int gap_a, int gap_b, bit da, bit db, bit ib);
    @(negedge clk);
    nr = 0; since = 0; min_int = 1000000; max_int = 0; prog_w = 0;
    hs_a = 0; hs_b = 0; hi_chg = 0; stop_feed = 0;
    init_a = 0; init_b = 0; done_a = 0; done_b = 0;
    en_done_a = da; en_done_b = db;
    fork
      feed_a(gap_a);
      feed_b(gap_b);
    join_none
    start = 1;
    @(negedge clk);
    start = 0;
    while (!cfg_prog) @(negedge clk);
    while (cfg_prog) @(negedge clk);
    repeat (3) @(negedge clk);
    init_a = 1;
    init_b = ib;
    for (int w = 0; w < 20000 && busy; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R10", "a_ready after load", a_ready, 0);
    stop_feed = 1;
    repeat (2) @(negedge clk);
    a_valid = 0; b_valid = 0;
  endtask

  task automatic check_bits(string tag);
    int md_a = 0, md_b = 0, mp_a = 0, mp_b = 0;
    for (int i = 0; i < TOTAL && i < nr; i++) begin
      if (i < BA) begin if (cap_a[i] !== pat(0, i / 8)[7 - (i % 8)]) md_a++; end
      else if (cap_a[i] !== 1'b1) mp_a++;
      if (i < BB) begin if (cap_b[i] !== pat(1, i / 8)[7 - (i % 8)]) md_b++; end
      else if (cap_b[i] !== 1'b1) mp_b++;
    end
    chk("R5", {tag, " A data bit mismatches"}, md_a, 0);
    chk("R5", {tag, " B data bit mismatches"}, md_b, 0);
    chk("R7", {tag, " A pad mismatches"}, mp_a, 0);
    chk("R7", {tag, " B pad mismatches"}, mp_b, 0);
    chk("R8", {tag, " rising edge count"}, nr, TOTAL);
    chk("R6", {tag, " data changes while clock high"}, hi_chg, 0);
    chk("R4", {tag, " min rise interval ok"}, int'(min_int >= 2 * HALF), 1);
    chk("R10", {tag, " bytes taken A"}, hs_a, NBA);
    chk("R10", {tag, " bytes taken B"}, hs_b, NBB);
  endtask

  task automatic test_reset();
    chk("R1", "cfg_prog", cfg_prog, 0);
    chk("R1", "cfg_clk", cfg_clk, 0);
    chk("R1", "dout a/b", {cfg_dout_a, cfg_dout_b}, 3);
    chk("R1", "ready a/b", {a_ready, b_ready}, 0);
    chk("R1", "busy+flags", {busy, ok_a, fail_a, ok_b, fail_b, init_err}, 0);
  endtask

  task automatic test_normal();
    run_load(0, 0, 1, 1, 1);
    chk("R2", "prog width", prog_w, PROGC);
    check_bits("normal");
    chk("R8", "ok a/b", {ok_a, ok_b}, 3);
    chk("R8", "fail a/b", {fail_a, fail_b}, 0);
    chk("R8", "busy low", busy, 0);
  endtask

  task automatic test_stall();
    run_load(300, 0, 1, 1, 1);
    check_bits("stall");
    chk("R9", "clock stretched", int'(max_int > 2 * HALF), 1);
    chk("R9", "ok a/b", {ok_a, ok_b}, 3);
  endtask

  task automatic test_one_fails();
    run_load(0, 0, 1, 0, 1);
    chk("R8", "ok_a independent", ok_a, 1);
    chk("R8", "fail_a", fail_a, 0);
    chk("R8", "fail_b", fail_b, 1);
    chk("R8", "ok_b", ok_b, 0);
    chk("R8", "rising edge count", nr, TOTAL);
  endtask

  task automatic test_init_timeout();
    run_load(0, 0, 1, 1, 0);
    chk("R3", "init_err", init_err, 1);
    chk("R3", "fail a/b", {fail_a, fail_b}, 1);
    chk("R3", "no clock edges", nr, 0);
    chk("R3", "busy low", busy, 0);
    chk("R2", "prog width", prog_w, PROGC);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    test_reset();
    test_normal();
    test_stall();
    test_one_fails();
    test_init_timeout();
    test_normal();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule